// File: doc/BRIEF.md
# Programmable Periodic Interrupt Timer

This block is a 16-bit down-counter that raises an interrupt at regular intervals. Software reaches it through a small 16-bit register port with separate write and read strobes and a byte offset. The port exposes three registers: a control/status word, a modulus (reload) word and a read-only view of the live count. The counter advances on a clock-enable pulse that runs at half the system clock. A power-of-two prescaler sits in front of it and divides that pulse by 1 to 32768.

On each prescaled tick the count goes down by one. A tick that finds the count already at zero marks an expiry. The expiry sets a sticky flag, and on that same tick the counter reloads, either from the modulus (reload mode) or from 0xFFFF (free-running mode). The interrupt pin is the flag gated by an enable bit. Software clears the flag by writing a one to it, or by writing the modulus. An overwrite bit chooses whether a new modulus is loaded into the counter at once or only at the next reload. A control write that touches only the enable-interrupt or flag bits leaves a running count alone. Any other change to the control word restarts the count under the new settings.

Top module: `periodic_tick_timer`

## Requirements
- R1: After reset, the control word reads 0x0000, the modulus reads 0xFFFF, the count reads 0xFFFF and irq is 0.
- R2: Offsets: control at 0, modulus at 2, count at 4. Control bits: run enable bit 0, reload mode bit 1, flag bit 2, interrupt enable bit 3, overwrite bit 4, two spare mode bits 5 and 6 that are stored but have no effect, and prescale select at bits 11:8. Bits 7 and 15:12 read 0. Reads from any other offset return 0, and writes to them change no register.
- R3: While running, the count changes once every 2^P pulses of tickEn, where P is the prescale select.
- R4: A tick with the count at 0 sets the flag and reloads the counter. In reload mode the flag is set every (modulus+1) ticks.
- R5: In free-running mode (reload bit 0) the counter reloads with 0xFFFF on expiry, whatever the modulus.
- R6: irq is 1 exactly when the flag and the interrupt enable bit are both 1.
- R7: Writing 1 to the flag bit clears the flag. Writing 0 leaves it as it is. A write can never set it.
- R8: Any write to the modulus clears the flag.
- R9: A modulus write with the overwrite bit set loads the count at once. With the overwrite bit clear, the count is left as it is and the new value is used from the next reload on.
- R10: A control write that differs from the current control word only in the interrupt enable or flag bits leaves the count untouched. Any other difference loads the counter with the new reload value (the modulus if the new reload bit is 1, else 0xFFFF) and clears the prescaler.
- R11: With the run enable bit at 0, the count and the prescaler hold.
- R12: Writes to the count offset have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | Clock-enable pulse at half the system clock |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 3 | Register byte offset |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data; 0 when rdEn is low |
| irq | output | 1 | Interrupt request |

## Verification
The expiry interval is swept over every pairing of four prescale settings and four modulus values, including modulus 0. The gap between consecutive interrupts is compared against (M+1)·2^(P+1) clock cycles, so a prescaler or reload off by one cycle shows up at once. Count deltas read back at fixed spacings under two prescale settings separate tick rate from reload behaviour. A scripted sequence at the largest prescale, where no tick can occur, separates restarting control writes from non-restarting ones and immediate modulus loads from deferred ones by the exact count value left behind. The flag sequences cover each way it can move: set by expiry, write-0 hold, write-1 clear, attempted software set and clear by modulus write.

// File: rtl/ptt_pkg.sv
package ptt_pkg;
  parameter int CNT_W  = 16;
  parameter int PRE_W  = 4;
  parameter int ADDR_W = 3;
  localparam int PRE_CNT_W = (1 << PRE_W) - 1;

  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_MOD  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] OFS_CNT  = ADDR_W'(4);

  localparam int B_EN   = 0;
  localparam int B_RLD  = 1;
  localparam int B_FLAG = 2;
  localparam int B_IE   = 3;
  localparam int B_OVW  = 4;
  localparam int B_SPA  = 5;
  localparam int B_SPB  = 6;
  localparam int B_PRE  = 8;

  typedef struct packed {
    logic             en;
    logic             rld;
    logic             ovw;
    logic             spareA;
    logic             spareB;
    logic [PRE_W-1:0] pre;
  } cfg_t;

  typedef struct packed {
    logic             load;
    logic             clrPre;
    logic [CNT_W-1:0] loadVal;
    logic [CNT_W-1:0] reloadVal;
    logic             run;
    logic [PRE_W-1:0] preSel;
  } strobe_t;
endpackage

// File: rtl/ptt_ctrl.sv
module ptt_ctrl
  import ptt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              expire,
  output strobe_t           strb,
  output logic [CNT_W-1:0]  ctrlRd,
  output logic [CNT_W-1:0]  modRd,
  output logic              flag,
  output logic              ieOut
);
  cfg_t             cfgQ, wrCfg;
  logic             ieQ, flagQ;
  logic [CNT_W-1:0] modQ;
  logic             isCtrlWr, isModWr, cfgChange;

  assign isCtrlWr = wrEn && (addr == OFS_CTRL);
  assign isModWr  = wrEn && (addr == OFS_MOD);

  always_comb begin
    wrCfg.en     = wrData[B_EN];
    wrCfg.rld    = wrData[B_RLD];
    wrCfg.ovw    = wrData[B_OVW];
    wrCfg.spareA = wrData[B_SPA];
    wrCfg.spareB = wrData[B_SPB];
    wrCfg.pre    = wrData[B_PRE +: PRE_W];
  end

  assign cfgChange = isCtrlWr && (wrCfg != cfgQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ  <= '0;
      ieQ   <= 1'b0;
      flagQ <= 1'b0;
      modQ  <= '1;
    end else begin
      if (isCtrlWr) begin
        cfgQ <= wrCfg;
        ieQ  <= wrData[B_IE];
      end
      if (isModWr) modQ <= wrData;
      if (expire) flagQ <= 1'b1;
      else if ((isCtrlWr && wrData[B_FLAG]) || isModWr) flagQ <= 1'b0;
    end
  end

  always_comb begin
    strb.clrPre    = cfgChange;
    strb.load      = cfgChange || (isModWr && cfgQ.ovw);
    strb.loadVal   = cfgChange ? (wrCfg.rld ? modQ : '1) : wrData;
    strb.reloadVal = cfgQ.rld ? modQ : '1;
    strb.run       = cfgQ.en;
    strb.preSel    = cfgQ.pre;
  end

  always_comb begin
    ctrlRd                  = '0;
    ctrlRd[B_EN]            = cfgQ.en;
    ctrlRd[B_RLD]           = cfgQ.rld;
    ctrlRd[B_FLAG]          = flagQ;
    ctrlRd[B_IE]            = ieQ;
    ctrlRd[B_OVW]           = cfgQ.ovw;
    ctrlRd[B_SPA]           = cfgQ.spareA;
    ctrlRd[B_SPB]           = cfgQ.spareB;
    ctrlRd[B_PRE +: PRE_W]  = cfgQ.pre;
  end

  assign modRd = modQ;
  assign flag  = flagQ;
  assign ieOut = ieQ;

  // R7
  flag_no_sw_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!flagQ && !expire) |=> !flagQ);

  // R8
  mod_wr_clears_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isModWr && !expire) |=> !flagQ);

  // R12
  cnt_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == OFS_CNT) |=> ($stable(modQ) && $stable(cfgQ) && $stable(ieQ)));
endmodule

// File: rtl/ptt_datapath.sv
module ptt_datapath
  import ptt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  strobe_t          strb,
  output logic [CNT_W-1:0] cntQ,
  output logic             expire
);
  logic [PRE_CNT_W-1:0] preCnt, preLim;
  logic                 preWrap, tick;

  assign preLim  = PRE_CNT_W'((32'd1 << strb.preSel) - 32'd1);
  assign preWrap = (preCnt == preLim);
  assign tick    = strb.run && tickEn && preWrap;
  assign expire  = tick && (cntQ == '0) && !strb.load;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else if (strb.clrPre) preCnt <= '0;
    else if (strb.run && tickEn) preCnt <= preWrap ? '0 : preCnt + PRE_CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cntQ <= '1;
    else if (strb.load) cntQ <= strb.loadVal;
    else if (tick) cntQ <= (cntQ == '0) ? strb.reloadVal : cntQ - CNT_W'(1);
  end

  // R11
  halt_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.run && !strb.load && !strb.clrPre) |=> ($stable(cntQ) && $stable(preCnt)));

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !strb.load && cntQ != '0) |=> (cntQ == $past(cntQ) - CNT_W'(1)));

  // R5
  reload_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> (cntQ == $past(strb.reloadVal)));
endmodule

// File: rtl/periodic_tick_timer.sv
module periodic_tick_timer
  import ptt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  output logic              irq
);
  strobe_t          strb;
  logic [CNT_W-1:0] ctrlRd, modRd, cntVal;
  logic             flag, ieOut, expire;

  ptt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .expire(expire), .strb(strb), .ctrlRd(ctrlRd), .modRd(modRd),
    .flag(flag), .ieOut(ieOut)
  );

  ptt_datapath u_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .strb(strb),
    .cntQ(cntVal), .expire(expire)
  );

  assign irq = flag && ieOut;

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      unique case (addr)
        OFS_CTRL: rdData = ctrlRd;
        OFS_MOD:  rdData = modRd;
        OFS_CNT:  rdData = cntVal;
        default:  rdData = '0;
      endcase
    end
  end

  // R6
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == OFS_CTRL && !wrData[B_IE]) |=> !irq);
endmodule

// File: tb/periodic_tick_timer_tb.sv
module periodic_tick_timer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        irq;
  int          checkCnt = 0;
  int          failCnt = 0;
  longint      cycleCnt = 0;

  periodic_tick_timer u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cycleCnt <= cycleCnt + 1;
  always @(negedge clk) tickEn <= rstN ? ~tickEn : 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic wrNow(input logic [2:0] a, input logic [15:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    #2 v = rdData;
    rdEn = 1'b0;
  endtask

  task automatic waitRise(output longint t);
    int n = 0;
    t = -1;
    while (n < 3000) begin
      @(negedge clk);
      #1;
      if (irq) begin
        t = cycleCnt;
        break;
      end
      n++;
    end
    if (t < 0) chk(1'b0, "R4 irq timeout", 0, 1);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checkCnt++; failCnt++;
    $display("FAIL R4 watchdog actual=running expected=done");
    finishRun();
  end

  initial begin
    logic [15:0] v, v2;
    longint t1, t2;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    #1 chk(irq == 1'b0, "R1 irq", irq, 0);
    rd(3'd0, v); chk(v == 16'h0000, "R1 ctrl", v, 16'h0000);
    rd(3'd2, v); chk(v == 16'hFFFF, "R1 mod", v, 16'hFFFF);
    rd(3'd4, v); chk(v == 16'hFFFF, "R1 count", v, 16'hFFFF);

    // R2 field readback and undefined offsets
    wr(3'd0, 16'hFFFA);
    rd(3'd0, v); chk(v == 16'h0F7A, "R2 ctrl fields", v, 16'h0F7A);
    wr(3'd0, 16'h0000);
    wr(3'd6, 16'h1234);
    rd(3'd6, v); chk(v == 16'h0000, "R2 undefined read", v, 0);
    rd(3'd1, v); chk(v == 16'h0000, "R2 odd offset read", v, 0);
    rd(3'd0, v); chk(v == 16'h0000, "R2 undef write ctrl", v, 0);
    rd(3'd2, v); chk(v == 16'hFFFF, "R2 undef write mod", v, 16'hFFFF);
    // R12 count offset is read-only
    wr(3'd4, 16'h0011);
    rd(3'd4, v); chk(v == 16'hFFFF, "R12 count write ignored", v, 16'hFFFF);
    rd(3'd2, v); chk(v == 16'hFFFF, "R12 mod untouched", v, 16'hFFFF);

    // R4 and R3: period sweep in reload mode
    for (int p = 0; p < 4; p++) begin
      for (int mi = 0; mi < 4; mi++) begin
        logic [15:0] m;
        logic [15:0] cw;
        longint expP;
        m = (mi == 0) ? 16'd0 : (mi == 1) ? 16'd1 : (mi == 2) ? 16'd3 : 16'd6;
        cw = 16'h000B | (16'(p) << 8);
        wr(3'd0, 16'h0000);
        wr(3'd2, m);
        wr(3'd0, cw);
        waitRise(t1);
        wrNow(3'd0, cw | 16'h0004);
        waitRise(t2);
        wrNow(3'd0, cw | 16'h0004);
        expP = longint'(m + 1) << (p + 1);
        chk((t2 - t1) == expP, "R4 R3 expiry period", t2 - t1, expP);
      end
    end

    // R9 / R10 at prescale 15, where no tick occurs
    wr(3'd0, 16'h0000);
    wr(3'd2, 16'd7);
    wr(3'd0, 16'h0F12);
    rd(3'd4, v); chk(v == 16'd7, "R10 restart loads modulus", v, 7);
    wr(3'd2, 16'd5);
    rd(3'd4, v); chk(v == 16'd5, "R9 overwrite loads now", v, 5);
    wr(3'd0, 16'h0F13);
    wr(3'd0, 16'h0F03);
    wr(3'd2, 16'd300);
    rd(3'd4, v); chk(v == 16'd5, "R9 deferred modulus", v, 5);
    rd(3'd2, v); chk(v == 16'd300, "R9 modulus stored", v, 300);
    wr(3'd0, 16'h0F0B);
    rd(3'd4, v); chk(v == 16'd5, "R10 ie-only write keeps count", v, 5);
    wr(3'd0, 16'h0E0B);
    rd(3'd4, v); chk(v == 16'd300, "R10 config change restarts", v, 300);

    // R11 halted counter holds
    wr(3'd0, 16'h0002);
    repeat (40) @(negedge clk);
    rd(3'd4, v); chk(v == 16'd300, "R11 halted hold", v, 300);

    // R3 tick rate at prescale 0 and 2
    wr(3'd0, 16'h0003);
    rd(3'd4, v);
    repeat (19) @(negedge clk);
    rd(3'd4, v2); chk((v - v2) == 16'd10, "R3 prescale 0 rate", v - v2, 10);
    wr(3'd0, 16'h0203);
    rd(3'd4, v);
    repeat (79) @(negedge clk);
    rd(3'd4, v2); chk((v - v2) == 16'd10, "R3 prescale 2 rate", v - v2, 10);

    // R5 free-running reload
    wr(3'd0, 16'h0000);
    wr(3'd0, 16'h0011);
    wr(3'd2, 16'd3);
    wr(3'd0, 16'h0019);
    waitRise(t1);
    chk(irq == 1'b1, "R6 irq with flag and enable", irq, 1);
    rd(3'd4, v); chk(v >= 16'hFFFD, "R5 free-run reloads 0xFFFF", v, 16'hFFFF);

    // R6 / R7 flag handling
    wr(3'd0, 16'h0011);
    #1 chk(irq == 1'b0, "R6 irq gated by enable", irq, 0);
    rd(3'd0, v); chk(v == 16'h0015, "R7 write 0 keeps flag", v, 16'h0015);
    wr(3'd0, 16'h0015);
    rd(3'd0, v); chk(v == 16'h0011, "R7 write 1 clears flag", v, 16'h0011);
    wr(3'd0, 16'h001D);
    #1 chk(irq == 1'b0, "R7 no software set irq", irq, 0);
    rd(3'd0, v); chk(v == 16'h0019, "R7 no software set", v, 16'h0019);

    // R8 modulus write clears flag
    wr(3'd2, 16'd2);
    waitRise(t1);
    wr(3'd2, 16'd7);
    rd(3'd0, v); chk(v == 16'h0019, "R8 modulus write clears flag", v, 16'h0019);
    #1 chk(irq == 1'b0, "R8 irq low after modulus write", irq, 0);

    finishRun();
  end
endmodule